// File: doc/BRIEF.md
# Audio Master and Bit Clock Generator

This block produces the timing strobes of a serial audio port from one fast kernel clock. A divider counts kernel cycles and produces a master-clock strobe. A prescaler counts master-clock strobes and produces a bit-clock strobe. A bit counter groups the bit strobes into frames and flags the first bit of each frame with a frame-sync level. All outputs are single-cycle enables (or a level, for frame sync) in the kernel clock domain. None of them is a gated clock.

The master clock runs at 256 or 512 times the frame rate, chosen by an oversampling select. A frame spans a power-of-two number of bits. The frame-length input holds that count minus one, so the valid values are 7, 15, 31, 63, 127 and 255. From the oversampling select and the frame length, the block derives how many master-clock strobes make up one bit.

In bypass mode the master-clock stage is skipped. The bit strobe then comes straight from the divider, and the frame is always 64 bits long. Configuration is captured into shadow registers while the generator is disabled and again at each frame start, so a change made while running never cuts a bit or a frame short.

Top module: `audio_clkgen`

## Requirements
- R1: A divider input of 0 or 1 divides the kernel clock by one. Any other value D divides by D.
- R2: Outside bypass, a master-clock strobe occurs once every D kernel cycles. A bit strobe occurs every D×512/2^N kernel cycles when oversampling select is 1, and every D×256/2^N kernel cycles when it is 0. Here the frame-length input equals 2^N−1 with N from 3 to 8.
- R3: Outside bypass, one frame contains exactly 2^N bit strobes, where the frame-length input equals 2^N−1.
- R4: Frame sync goes high in the same cycle as the bit strobe that begins a frame. It stays high until the next bit strobe and is low for every other bit of the frame.
- R5: In bypass, a bit strobe occurs every D kernel cycles, every frame is 64 bits whatever the frame-length input holds, and no master-clock strobe is produced.
- R6: Master-clock strobes appear only while the master-clock enable is 1 and bypass is off. With the enable at 0, bit strobes and frames continue unchanged.
- R7: While running, changes to the divider, oversampling select, bypass select or frame length take effect at the start of the next frame. The frame already in progress completes with the old settings.
- R8: While disabled, all outputs are low and the settings are loaded continuously. After enable, the first bit strobe arrives one full bit period later and begins a frame.
- R9: During and directly after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_en_i | input | 1 | Run enable for the generator |
| div_i | input | DIV_W (6) | Divider value; 0 and 1 both mean divide by one |
| osr512_i | input | 1 | 1: master clock at 512× frame rate, 0: 256× |
| bypass_i | input | 1 | 1: skip the master-clock stage and use a fixed 64-bit frame |
| mclk_en_i | input | 1 | Allows master-clock strobes |
| flen_i | input | FLEN_W (8) | Bits per frame minus one (2^N−1) |
| mclk_stb_o | output | 1 | One-cycle master-clock strobe |
| bclk_stb_o | output | 1 | One-cycle bit-clock strobe |
| fsync_o | output | 1 | High during the first bit of each frame |

## Verification
The assertions assume that the frame-length input always holds a value of the form 2^N−1 with N from 3 to 8. Under that assumption the bit counter wraps exactly at a frame end and the prescaler bound is meaningful. They also assume that the divider, oversampling and frame-length inputs are settled before enable rises. The stimulus uses only legal frame lengths and sets every input at least two cycles before raising enable. It changes settings while running only just after a frame has started, so each change waits a whole frame before the capture point. The master-clock enable is held steady within a run, because the block gates it live and does not capture it with the shadowed settings.

// File: rtl/acg_pkg.sv
package acg_pkg;
    parameter int DIV_W  = 6;
    parameter int FLEN_W = 8;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              osr512;
        logic              bypass;
        logic [FLEN_W-1:0] flen;
    } acg_cfg_t;
endpackage

// File: rtl/acg_divider.sv
module acg_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_m1_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_m1_i);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R1: the count never passes the terminal value while running
    a_r1_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q <= div_m1_i));
endmodule

// File: rtl/acg_bit_timer.sv
module acg_bit_timer #(
    parameter int PRE_W = 6,
    parameter int IDX_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             bypass_i,
    input  logic [PRE_W-1:0] ratio_m1_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             step_o,
    output logic             wrap_o,
    output logic             fsync_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [IDX_W-1:0] idx;
    } bt_state_t;

    bt_state_t s_d, s_q;
    logic      pre_hit;

    always_comb begin
        s_d     = s_q;
        pre_hit = (s_q.pre == ratio_m1_i);
        step_o  = tick_i && (bypass_i || pre_hit);
        wrap_o  = step_o && (s_q.idx >= last_i);
        fsync_o = (s_q.idx == '0);
        if (!run_i) begin
            s_d.pre = '0;
            s_d.idx = '1;
        end else begin
            if (tick_i && !bypass_i)
                s_d.pre = pre_hit ? '0 : s_q.pre + 1'b1;
            if (step_o)
                s_d.idx = wrap_o ? '0 : s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{pre: '0, idx: '1};
        else         s_q <= s_d;
    end

    // R2: prescaler stays inside the bit period
    a_r2_pre_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !bypass_i) |-> (s_q.pre <= ratio_m1_i));
    // R4: frame sync holds for the whole first bit
    a_r4_fs_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && fsync_o && !step_o) |=> fsync_o);
    // R4: frame sync only starts right after a frame wrap
    a_r4_fs_from_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fsync_o) |-> $past(wrap_o));
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import acg_pkg::*;
#(
    parameter int DIV_W_P  = DIV_W,
    parameter int FLEN_W_P = FLEN_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                gen_en_i,
    input  logic [DIV_W_P-1:0]  div_i,
    input  logic                osr512_i,
    input  logic                bypass_i,
    input  logic                mclk_en_i,
    input  logic [FLEN_W_P-1:0] flen_i,
    output logic                mclk_stb_o,
    output logic                bclk_stb_o,
    output logic                fsync_o
);
    localparam int N_MIN     = 3;
    localparam int N_MAX     = FLEN_W_P;
    localparam int BASE_W    = FLEN_W_P + 2;
    localparam int RATIO_MAX = (2 << FLEN_W_P) >> N_MIN;
    localparam int PRE_W     = $clog2(RATIO_MAX);
    localparam int BYP_LAST  = 63;

    typedef struct packed {
        logic [DIV_W_P-1:0]  div;
        logic                osr512;
        logic                bypass;
        logic [FLEN_W_P-1:0] flen;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic mclk;
        logic bclk;
    } top_state_t;

    top_state_t          s_d, s_q;
    logic [DIV_W_P-1:0]  div_m1;
    logic [BASE_W-1:0]   base, ratio;
    logic [PRE_W-1:0]    ratio_m1;
    logic [FLEN_W_P-1:0] last_idx;
    logic                tick, step, wrap, fs;
    int                  n_bits;

    // effective settings from the shadow copy
    always_comb begin
        div_m1 = (s_q.cfg.div <= DIV_W_P'(1)) ? '0 : s_q.cfg.div - 1'b1;
        n_bits = $countones(s_q.cfg.flen);
        if (n_bits < N_MIN) n_bits = N_MIN;
        if (n_bits > N_MAX) n_bits = N_MAX;
        base     = s_q.cfg.osr512 ? BASE_W'(2 << FLEN_W_P) : BASE_W'(1 << FLEN_W_P);
        ratio    = base >> n_bits;
        ratio_m1 = PRE_W'(ratio - 1'b1);
        last_idx = s_q.cfg.bypass ? FLEN_W_P'(BYP_LAST) : s_q.cfg.flen;
    end

    acg_divider #(.DIV_W(DIV_W_P)) div_i0 (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (gen_en_i),
        .div_m1_i (div_m1),
        .tick_o   (tick)
    );

    acg_bit_timer #(.PRE_W(PRE_W), .IDX_W(FLEN_W_P)) bt_i0 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (gen_en_i),
        .tick_i     (tick),
        .bypass_i   (s_q.cfg.bypass),
        .ratio_m1_i (ratio_m1),
        .last_i     (last_idx),
        .step_o     (step),
        .wrap_o     (wrap),
        .fsync_o    (fs)
    );

    always_comb begin
        s_d = s_q;
        if (!gen_en_i || wrap) begin
            s_d.cfg.div    = div_i;
            s_d.cfg.osr512 = osr512_i;
            s_d.cfg.bypass = bypass_i;
            s_d.cfg.flen   = flen_i;
        end
        s_d.mclk = tick && mclk_en_i && !s_q.cfg.bypass;
        s_d.bclk = step;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign mclk_stb_o = s_q.mclk;
    assign bclk_stb_o = s_q.bclk;
    assign fsync_o    = fs;

    // R4: frame sync rises together with a bit strobe
    a_r4_fs_on_bclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fsync_o) |-> bclk_stb_o);
    // R5: no master strobe after a bypass cycle
    a_r5_no_mclk_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cfg.bypass |=> !mclk_stb_o);
    // R6: master strobe suppressed while its enable is low
    a_r6_mclk_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mclk_en_i |=> !mclk_stb_o);
    // R7: shadow settings hold between frame starts while running
    a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gen_en_i && !wrap) |=> $stable(s_q.cfg));
    // R8: disabled generator stays quiet
    a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gen_en_i |=> (!bclk_stb_o && !mclk_stb_o && !fsync_o));
endmodule

// File: tb/audio_clkgen_tb_top.sv
`timescale 1ns/1ps
module audio_clkgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b0;
    logic [5:0] div = '0;
    logic       osr512 = 1'b0;
    logic       bypass = 1'b0;
    logic       mclk_en = 1'b0;
    logic [7:0] flen = 8'd7;
    logic       mclk_stb, bclk_stb, fsync;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int    gap;
        bit    fs;
        int    mcnt;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    audio_clkgen dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .gen_en_i   (gen_en),
        .div_i      (div),
        .osr512_i   (osr512),
        .bypass_i   (bypass),
        .mclk_en_i  (mclk_en),
        .flen_i     (flen),
        .mclk_stb_o (mclk_stb),
        .bclk_stb_o (bclk_stb),
        .fsync_o    (fsync)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(int n, int gap, bit fs, int mcnt, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.gap = gap; e.fs = (i == 0) ? fs : 1'b0; e.mcnt = mcnt; e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic set_cfg(int d, bit o, bit b, bit m, int f);
        div = 6'(d); osr512 = o; bypass = b; mclk_en = m; flen = 8'(f);
    endtask

    task automatic start_run();
        repeat (2) @(posedge clk);
        #2 gen_en = 1'b1;
    endtask

    task automatic drain_and_stop();
        while (exp_q.size() != 0) begin
            @(posedge clk); #2;
        end
        gen_en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check(bclk_stb == 1'b0 && mclk_stb == 1'b0 && fsync == 1'b0, "R8",
              "idle outputs", {bclk_stb, mclk_stb, fsync}, 0);
    endtask

    // one frame plus the start of the next, same settings throughout
    task automatic frames(int len, int per, int mc, string tag);
        push(1, per, 1'b1, mc, "R8");
        push(len - 1, per, 1'b0, mc, tag);
        push(1, per, 1'b1, mc, tag);
    endtask

    // scoreboard monitor
    int gap_cnt = 0;
    int mcl_cnt = 0;
    always @(negedge clk) begin
        if (!gen_en) begin
            gap_cnt = 0;
            mcl_cnt = 0;
        end else begin
            if (mclk_stb) mcl_cnt++;
            if (bclk_stb) begin
                if (exp_q.size() != 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(gap_cnt == e.gap, e.tag, "bit period", gap_cnt, e.gap);
                    check(fsync == e.fs, {e.tag, "/R4"}, "frame sync", fsync, e.fs);
                    check(mcl_cnt == e.mcnt, {e.tag, "/R6"}, "master strobes per bit", mcl_cnt, e.mcnt);
                end
                gap_cnt = 1;
                mcl_cnt = 0;
            end else begin
                gap_cnt++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(mclk_stb == 0 && bclk_stb == 0 && fsync == 0, "R9", "outputs in reset",
              {mclk_stb, bclk_stb, fsync}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check(mclk_stb == 0 && bclk_stb == 0 && fsync == 0, "R9", "outputs after reset",
              {mclk_stb, bclk_stb, fsync}, 0);

        // R2: 512x, divide 1, 32-bit frame: 16 master strobes per bit
        set_cfg(1, 1, 0, 1, 31);
        frames(32, 16, 16, "R2");
        start_run(); drain_and_stop();

        // R3: 256x, divide 2, 256-bit frame: one master strobe per bit
        set_cfg(2, 0, 0, 1, 255);
        frames(256, 2, 1, "R3");
        start_run(); drain_and_stop();

        // R1: divider 0 and 1 give the same timing
        set_cfg(0, 0, 0, 1, 7);
        frames(8, 32, 32, "R1");
        start_run(); drain_and_stop();
        set_cfg(1, 0, 0, 1, 7);
        frames(8, 32, 32, "R1");
        start_run(); drain_and_stop();

        // R6: master enable off, bits still run; 512x div 3, 16-bit frame
        set_cfg(3, 1, 0, 0, 15);
        frames(16, 96, 0, "R6");
        start_run(); drain_and_stop();

        // R5: bypass, divider 8, frame-length input ignored, no master strobes
        set_cfg(8, 0, 1, 1, 7);
        frames(64, 8, 0, "R5");
        start_run(); drain_and_stop();

        // R5: bypass with divider 0 -> bit every kernel cycle
        set_cfg(0, 1, 1, 1, 15);
        frames(64, 1, 0, "R5");
        start_run(); drain_and_stop();

        // R7: change settings during the first frame; new ones start at the next frame
        set_cfg(0, 0, 0, 1, 7);
        push(1, 32, 1'b1, 32, "R8");
        push(7, 32, 1'b0, 32, "R7");
        push(1, 32, 1'b1, 32, "R7");
        push(15, 96, 1'b0, 32, "R7");
        push(1, 96, 1'b1, 32, "R7");
        start_run();
        while (fsync != 1'b1) begin
            @(posedge clk); #2;
        end
        set_cfg(3, 1, 0, 1, 15);
        drain_and_stop();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule